// File: doc/BRIEF.md
# Processor Watchdog with Interrupt/Reset Steering

This block supervises a processor by counting down a programmed interval on a slow tick and flagging a timeout when software stops servicing it. The whole configuration is one 8-bit register: a steering bit, a 5-bit multiplier and a 2-bit resolution select. The interval in ticks is the multiplier times the tick count of the selected resolution, with the tick running at 16 Hz by default.

The countdown restarts on any edge of the external kick pin, after a two-stage synchronizer, and on any write to the register. On expiry the watchdog flag is raised. The steering bit then selects one of two outcomes. The first is a level interrupt that only a write of 00h releases. The second is a reset pulse of fixed length, which also clears the register and pulses a clear for the frequency-test bit kept elsewhere. A power-down level holds the register at zero, which disables the function.

Control and status pins are plain levels and one-cycle strobes. The block has no streaming interface, so no back-pressure rules apply.

Top module: `wdog_steer`

## Requirements
- R1: After reset the register reads 00h and wdf_o, irq_o, rst_pulse_o and ft_clr_o are low. A write stores the byte as is. Bit 7 is the steering bit, bits 6..2 are the multiplier and bits 1..0 are the resolution.
- R2: The timeout falls on the Nth tick after a restart. N is the multiplier times 1, 4, 16 or 64 ticks, for resolution codes 00, 01, 10 and 11. With the default 16 Hz tick these are 1/16 s, 1/4 s, 1 s and 4 s.
- R3: A rising or a falling edge on kick_i, seen after two synchronizer stages, reloads the countdown from the register.
- R4: Any write to the register reloads the countdown from the written value. A write in the same cycle as an expiring tick suppresses that timeout.
- R5: With steering 0, a timeout sets wdf_o and irq_o. irq_o stays high through flag reads and nonzero writes, and falls only on a write of 00h.
- R6: With steering 1, a timeout sets wdf_o and leaves irq_o low. In the same cycle it clears the register to 00h and raises ft_clr_o for exactly one cycle. It also starts rst_pulse_o, which stays high for PULSE_TICKS ticks (2 by default, 125 ms).
- R7: A flags read (flag_rd_i) clears wdf_o. A timeout in the same cycle wins, and wdf_o stays set.
- R8: A multiplier of zero disables the countdown. No timeout occurs for any number of ticks or kick edges.
- R9: While pwr_down_i is high the register is held at 00h, writes are ignored, irq_o is released and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle tick pulse at TICKS_PER_SEC |
| kick_i | input | 1 | Asynchronous kick pin; either edge restarts |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| flag_rd_i | input | 1 | Flags-register read strobe |
| pwr_down_i | input | 1 | Power-down level |
| cfg_q_o | output | 8 | Current register value |
| wdf_o | output | 1 | Watchdog timeout flag |
| irq_o | output | 1 | Interrupt (steering 0) |
| rst_pulse_o | output | 1 | Reset pulse, active high (steering 1) |
| ft_clr_o | output | 1 | One-cycle clear for the frequency-test bit |

## Verification
The interval is tried with all four resolution codes and several multipliers. The flag is checked one tick before the expected timeout and exactly at it, which separates a correct product from off-by-one or wrong-scale counting. Restarts are driven by a rising kick, a falling kick and a rewrite, each placed late in a countdown, so that a missed reload shows up as an early timeout. Both steering settings are run to timeout. Each then faces the clear events that must not release it and the one that must. A zero multiplier, a flag read coinciding with expiry, and power-down with a pending interrupt cover the remaining corners.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned MULT_W = 5;

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [1:0]        res;
  } wdog_cfg_t;

  // ticks per resolution step for a tick rate of tps per second
  function automatic int unsigned res_ticks(input logic [1:0] res, input int unsigned tps);
    case (res)
      2'b00:   return tps / 16;
      2'b01:   return tps / 4;
      2'b10:   return tps;
      default: return tps * 4;
    endcase
  endfunction

endpackage

// File: rtl/wdog_sync_edge.sv
module wdog_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign edge_o = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  // zero means idle: a zero load or a finished count never expires
  assign expire = tick && !load && !clr && (cnt == CNT_W'(1));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic active
);
  localparam int unsigned W = $clog2(PULSE_TICKS + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (start)            cnt <= W'(PULSE_TICKS);
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != 0);
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 16,
  parameter int unsigned PULSE_TICKS   = 2,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       cfg_wr_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic       flag_rd_i,
  input  logic       pwr_down_i,
  output logic [7:0] cfg_q_o,
  output logic       wdf_o,
  output logic       irq_o,
  output logic       rst_pulse_o,
  output logic       ft_clr_o
);
  localparam int unsigned MAX_TICKS = ((1 << MULT_W) - 1) * 4 * TICKS_PER_SEC;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  wdog_cfg_t        cfg, wcfg, src;
  logic             wr_ok, kick_edge, load, expire, timeout_rst;
  logic [CNT_W-1:0] load_val;

  assign wcfg  = wdog_cfg_t'(cfg_wdata_i);
  assign wr_ok = cfg_wr_i && !pwr_down_i;

  wdog_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(kick_i), .edge_o(kick_edge)
  );

  assign src      = wr_ok ? wcfg : cfg;
  assign load     = wr_ok || kick_edge;
  assign load_val = CNT_W'(src.mult) * CNT_W'(res_ticks(src.res, TICKS_PER_SEC));

  wdog_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(pwr_down_i), .load(load),
    .load_val(load_val), .tick(tick_i), .expire(expire)
  );

  assign timeout_rst = expire && cfg.steer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cfg <= '0;
    else if (pwr_down_i)  cfg <= '0;
    else if (wr_ok)       cfg <= wcfg;
    else if (timeout_rst) cfg <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdf_o    <= 1'b0;
      irq_o    <= 1'b0;
      ft_clr_o <= 1'b0;
    end else begin
      ft_clr_o <= timeout_rst;
      if (expire)         wdf_o <= 1'b1;
      else if (flag_rd_i) wdf_o <= 1'b0;
      if (pwr_down_i)                       irq_o <= 1'b0;
      else if (expire && !cfg.steer)        irq_o <= 1'b1;
      else if (wr_ok && cfg_wdata_i == '0)  irq_o <= 1'b0;
    end
  end

  wdog_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .start(timeout_rst), .tick(tick_i), .active(rst_pulse_o)
  );

  assign cfg_q_o = cfg;
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       cfg_wr_i,
  input logic [7:0] cfg_wdata_i,
  input logic       flag_rd_i,
  input logic       pwr_down_i,
  input logic [7:0] cfg_q_o,
  input logic       wdf_o,
  input logic       irq_o,
  input logic       rst_pulse_o,
  input logic       ft_clr_o
);
  // R5: only a 00h write or power-down drops the interrupt
  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !pwr_down_i && !(cfg_wr_i && cfg_wdata_i == 8'h00) |=> irq_o);

  // R6: a starting reset pulse comes with a cleared register and a set flag
  a_r6_cfg_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse_o) |-> (cfg_q_o == 8'h00) && wdf_o && !$rose(irq_o));

  // R6: the frequency-test clear lies inside a reset pulse and lasts one cycle
  a_r6_ft_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ft_clr_o |-> rst_pulse_o);
  a_r6_ft_single: assert property (@(posedge clk) disable iff (!rst_n)
    ft_clr_o |=> !ft_clr_o);

  // R7: a read without a tick always clears the flag
  a_r7_flag_read: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd_i && !tick_i |=> !wdf_o);

  // R8: zero multiplier never produces a new timeout
  a_r8_zero_mult: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q_o[6:2] == 5'd0) && !cfg_wr_i |=> !$rose(wdf_o));

  // R9: power-down empties the register and releases the interrupt
  a_r9_pwr_down: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> (cfg_q_o == 8'h00) && !irq_o);
endmodule

bind wdog_steer wdog_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfg_wr_i(cfg_wr_i),
  .cfg_wdata_i(cfg_wdata_i), .flag_rd_i(flag_rd_i), .pwr_down_i(pwr_down_i),
  .cfg_q_o(cfg_q_o), .wdf_o(wdf_o), .irq_o(irq_o), .rst_pulse_o(rst_pulse_o),
  .ft_clr_o(ft_clr_o)
);

// File: tb/wdog_steer_bench.sv
module wdog_steer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, kick_i = 1'b0, cfg_wr_i = 1'b0, flag_rd_i = 1'b0, pwr_down_i = 1'b0;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic [7:0] cfg_q_o;
  logic       wdf_o, irq_o, rst_pulse_o, ft_clr_o;

  typedef struct {
    string      req;
    logic       wdf, irq, rst, ft;
    logic [7:0] cfg;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  wdog_steer u_wdog_steer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i), .cfg_wr_i(cfg_wr_i),
    .cfg_wdata_i(cfg_wdata_i), .flag_rd_i(flag_rd_i), .pwr_down_i(pwr_down_i),
    .cfg_q_o(cfg_q_o), .wdf_o(wdf_o), .irq_o(irq_o), .rst_pulse_o(rst_pulse_o),
    .ft_clr_o(ft_clr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares queued expectations just after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({wdf_o, irq_o, rst_pulse_o, ft_clr_o, cfg_q_o} !== {e.wdf, e.irq, e.rst, e.ft, e.cfg}) begin
        errors++;
        $display("FAIL %s: got wdf=%b irq=%b rst=%b ft=%b cfg=%h, expected wdf=%b irq=%b rst=%b ft=%b cfg=%h",
                 e.req, wdf_o, irq_o, rst_pulse_o, ft_clr_o, cfg_q_o,
                 e.wdf, e.irq, e.rst, e.ft, e.cfg);
      end
    end
  end

  task automatic expect_st(string req, logic wdf, logic irq, logic rst, logic ft, logic [7:0] cfg);
    q.push_back('{req, wdf, irq, rst, ft, cfg});
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); cfg_wr_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk); cfg_wr_i = 1'b0;
  endtask

  task automatic rd_flags();
    @(negedge clk); flag_rd_i = 1'b1;
    @(negedge clk); flag_rd_i = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic kick();
    @(negedge clk); kick_i = ~kick_i;
    repeat (3) @(negedge clk);
  endtask

  task automatic cleanup();
    wr(8'h00);
    rd_flags();
    expect_st("R1 idle", 0, 0, 0, 0, 8'h00);
  endtask

  task automatic interval(string req, logic [7:0] v, int n);
    wr(v);
    ticks(n - 1);
    expect_st(req, 0, 0, 0, 0, v);
    ticks(1);
    expect_st(req, 1, 1, 0, 0, v);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_st("R1 reset", 0, 0, 0, 0, 8'h00);
    wr(8'h5D);
    expect_st("R1 readback", 0, 0, 0, 0, 8'h5D);
    wr(8'h00);

    // R2: interval = multiplier * {1,4,16,64} ticks
    interval("R2 res00 x1", 8'h04, 1);
    interval("R2 res01 x2", 8'h09, 8);
    interval("R2 res10 x3", 8'h0E, 48);
    interval("R2 res11 x1", 8'h07, 64);

    // R3: rising then falling kick edge restarts
    wr(8'h09); ticks(6); kick(); ticks(7);
    expect_st("R3 rising kick", 0, 0, 0, 0, 8'h09);
    ticks(1);
    expect_st("R3 rising kick", 1, 1, 0, 0, 8'h09);
    cleanup();
    wr(8'h09); ticks(6); kick(); ticks(7);
    expect_st("R3 falling kick", 0, 0, 0, 0, 8'h09);
    ticks(1);
    expect_st("R3 falling kick", 1, 1, 0, 0, 8'h09);
    cleanup();

    // R4: rewrite restarts
    wr(8'h09); ticks(6); wr(8'h09); ticks(7);
    expect_st("R4 rewrite", 0, 0, 0, 0, 8'h09);
    ticks(1);
    expect_st("R4 rewrite", 1, 1, 0, 0, 8'h09);
    cleanup();

    // R5: interrupt is sticky until 00h written
    wr(8'h04); ticks(1);
    expect_st("R5 irq set", 1, 1, 0, 0, 8'h04);
    rd_flags();
    expect_st("R5 irq after read", 0, 1, 0, 0, 8'h04);
    wr(8'h08);
    expect_st("R5 irq after nonzero write", 0, 1, 0, 0, 8'h08);
    wr(8'h00);
    expect_st("R5 irq cleared by 00h", 0, 0, 0, 0, 8'h00);

    // R6: reset steering
    wr(8'h84); ticks(1);
    expect_st("R6 timeout", 1, 0, 1, 1, 8'h00);
    @(negedge clk);
    expect_st("R6 ft one cycle", 1, 0, 1, 0, 8'h00);
    ticks(1);
    expect_st("R6 pulse held", 1, 0, 1, 0, 8'h00);
    ticks(1);
    expect_st("R6 pulse ends", 1, 0, 0, 0, 8'h00);
    rd_flags();
    expect_st("R7 flag read", 0, 0, 0, 0, 8'h00);

    // R7: timeout wins over simultaneous read
    wr(8'h04);
    @(negedge clk); tick_i = 1'b1; flag_rd_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; flag_rd_i = 1'b0;
    expect_st("R7 set wins", 1, 1, 0, 0, 8'h04);
    cleanup();

    // R8: multiplier zero never times out
    wr(8'h83); ticks(100); kick(); ticks(10);
    expect_st("R8 zero mult", 0, 0, 0, 0, 8'h83);
    wr(8'h03); ticks(70);
    expect_st("R8 zero mult steer0", 0, 0, 0, 0, 8'h03);

    // R9: power-down
    wr(8'h04); ticks(1);
    expect_st("R9 pre", 1, 1, 0, 0, 8'h04);
    rd_flags();
    @(negedge clk); pwr_down_i = 1'b1;
    @(negedge clk);
    expect_st("R9 pwr clears", 0, 0, 0, 0, 8'h00);
    wr(8'h04); ticks(5);
    expect_st("R9 writes ignored", 0, 0, 0, 0, 8'h00);
    @(negedge clk); pwr_down_i = 1'b0;
    ticks(3);
    expect_st("R9 stays off", 0, 0, 0, 0, 8'h00);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule